// File: doc/BRIEF.md
# Instruction Decoder for a Compact 64-bit RISC Subset

This block turns one 32-bit instruction word into the register indices, immediate value and control signals that an execute stage needs. It recognises a small set of operate (arithmetic, logical, compare, conditional move), memory, branch, register-indirect jump and halt instructions. Every other word is reported as illegal, and an illegal word enables nothing.

The decode is computed combinationally and held in one output register. The outputs therefore describe the word that was presented at the previous rising clock edge. A valid flag travels with the word. When the flag is low, every control output is quiet. The destination-write enable is always suppressed for register 31, which reads as zero.

Top module: `insn_decoder`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: Outputs change one rising edge after the inputs are sampled, and `dec_valid` follows `insn_valid` with that same one-cycle delay.
- R3: `ra_idx` is always word bits 25:21 and `rb_idx` is always bits 20:16, whatever the opcode and whatever the valid flag.
- R4: For major opcode (bits 31:26) 0x10, function code (bits 11:5) 0x20 gives `alu_op`=0 (add) and 0x29 gives 1 (subtract). For opcode 0x11, function 0x20 gives 2 (or), 0x40 gives 3 (xor), 0x24 gives 4 (move-if-equal) and 0x4D gives 5 (signed less-than). Any other function code under these two opcodes is illegal.
- R5: For an operate word, bit 12 set gives `b_sel_imm`=1 and `imm` = bits 20:13 zero-extended. Bit 12 clear gives `b_sel_imm`=0 and `imm`=0.
- R6: An operate word writes the register named in bits 4:0. It drives `dst_idx` to that field and sets `reg_wen`.
- R7: Opcode 0x29 (load) sets `mem_rd`. Opcode 0x2D (store) sets `mem_wr`. Both set `alu_op`=0 and `b_sel_imm`=1, and both drive `imm` to bits 15:0 sign-extended. The load writes ra; the store writes no register and gives `dst_idx`=0.
- R8: `br_kind` is 1 for opcode 0x39 (taken if ra is zero), 2 for 0x3D (taken if ra is nonzero) and 3 for 0x30 and 0x34 (always taken). `imm` is bits 20:0 sign-extended and multiplied by 4. The two conditional forms write no register and give `dst_idx`=0. The two unconditional forms set `link` and write ra.
- R9: Opcode 0x1A sets `jump` and `link` and writes ra, with `imm`=0. Bits 15:0, including the kind hint in 15:14, have no effect on any output.
- R10: Opcode 0x00 sets `halt` and nothing else; bits 25:0 affect only `ra_idx` and `rb_idx`.
- R11: Any other opcode, or an unlisted operate function, sets `dec_illegal`. It clears `reg_wen`, `mem_rd`, `mem_wr`, `jump`, `link`, `halt`, `br_kind`, `alu_op`, `b_sel_imm`, `imm` and `dst_idx`.
- R12: A destination of register 31 keeps `dst_idx`=31 but clears `reg_wen`.
- R13: With `insn_valid` low, all outputs except `ra_idx` and `rb_idx` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Word on `insn` is to be decoded |
| insn | input | 32 | Instruction word |
| dec_valid | output | 1 | Registered valid flag |
| dec_illegal | output | 1 | Word is not in the recognised set |
| ra_idx | output | 5 | First register field |
| rb_idx | output | 5 | Second register field |
| dst_idx | output | 5 | Destination register index |
| reg_wen | output | 1 | Register write enable |
| alu_op | output | 3 | ALU function (0 add, 1 sub, 2 or, 3 xor, 4 move-if-equal, 5 less-than) |
| b_sel_imm | output | 1 | Second ALU operand comes from `imm` |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| br_kind | output | 2 | 0 none, 1 if zero, 2 if nonzero, 3 always |
| jump | output | 1 | Register-indirect jump |
| link | output | 1 | Destination receives the return address |
| halt | output | 1 | Halt instruction |
| imm | output | 64 | Immediate or byte displacement |

## Verification
Decode state lasts for only one word, so a wrong internal value appears at the ports on the cycle right after that word is sampled. It shows as a wrong enable, index, operation code or immediate. It cannot persist beyond the next word unless the next word exposes it again. The bench therefore compares every output against an independent model on every cycle. It mixes directed words from each class with a biased random stream that covers listed opcodes, near-miss function codes and unlisted opcodes. It also drives valid-low gaps and words that differ only in bits that must not matter.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

    localparam int OPC_W  = 6;
    localparam int FN_W   = 7;
    localparam int RIDX_W = 5;
    localparam logic [RIDX_W-1:0] ZERO_REG = 5'd31;

    localparam logic [OPC_W-1:0] OPC_HALT  = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ARITH = 6'h10;
    localparam logic [OPC_W-1:0] OPC_LOGIC = 6'h11;
    localparam logic [OPC_W-1:0] OPC_JMP   = 6'h1A;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h29;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2D;
    localparam logic [OPC_W-1:0] OPC_BR    = 6'h30;
    localparam logic [OPC_W-1:0] OPC_BSR   = 6'h34;
    localparam logic [OPC_W-1:0] OPC_BEQZ  = 6'h39;
    localparam logic [OPC_W-1:0] OPC_BNEZ  = 6'h3D;

    typedef enum logic [3:0] {
        CL_ILL, CL_OPER, CL_LOAD, CL_STORE, CL_BEQZ,
        CL_BNEZ, CL_BR, CL_BSR, CL_JMP, CL_HALT
    } iclass_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_OR = 3'd2,
        ALU_XOR = 3'd3, ALU_CMOVEQ = 3'd4, ALU_CMPLT = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        BRK_NONE = 2'd0, BRK_EQZ = 2'd1, BRK_NEZ = 2'd2, BRK_ALWAYS = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic              vld;
        logic              illegal;
        logic [RIDX_W-1:0] ra;
        logic [RIDX_W-1:0] rb;
        logic [RIDX_W-1:0] dst;
        logic              we;
        alu_op_e           alu;
        logic              bimm;
        logic              rd;
        logic              wr;
        br_kind_e          br;
        logic              jump;
        logic              link;
        logic              halt;
    } ctl_t;

endpackage

// File: rtl/rdec_class.sv
module rdec_class
    import rdec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output iclass_e          cls
);
    always_comb begin
        case (opcode)
            OPC_ARITH, OPC_LOGIC: cls = CL_OPER;
            OPC_LOAD:             cls = CL_LOAD;
            OPC_STORE:            cls = CL_STORE;
            OPC_BEQZ:             cls = CL_BEQZ;
            OPC_BNEZ:             cls = CL_BNEZ;
            OPC_BR:               cls = CL_BR;
            OPC_BSR:              cls = CL_BSR;
            OPC_JMP:              cls = CL_JMP;
            OPC_HALT:             cls = CL_HALT;
            default:              cls = CL_ILL;
        endcase
    end
endmodule

// File: rtl/rdec_operate.sv
module rdec_operate
    import rdec_pkg::*;
(
    input  logic            logic_grp,
    input  logic [FN_W-1:0] func,
    output alu_op_e         op,
    output logic            legal
);
    always_comb begin
        op    = ALU_ADD;
        legal = 1'b1;
        case ({logic_grp, func})
            {1'b0, 7'h20}: op = ALU_ADD;
            {1'b0, 7'h29}: op = ALU_SUB;
            {1'b1, 7'h20}: op = ALU_OR;
            {1'b1, 7'h40}: op = ALU_XOR;
            {1'b1, 7'h24}: op = ALU_CMOVEQ;
            {1'b1, 7'h4D}: op = ALU_CMPLT;
            default:       legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/rdec_imm.sv
module rdec_imm
    import rdec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  iclass_e         cls,
    input  logic [20:0]     low_bits,
    input  logic            lit_form,
    output logic [XLEN-1:0] imm
);
    localparam int LIT_W  = 8;
    localparam int OFF_W  = 16;
    localparam int DISP_W = 23;

    logic [XLEN-1:0] lit_ext, off_ext, disp_ext;

    assign lit_ext  = {{(XLEN-LIT_W){1'b0}}, low_bits[20:13]};
    assign off_ext  = {{(XLEN-OFF_W){low_bits[15]}}, low_bits[15:0]};
    assign disp_ext = {{(XLEN-DISP_W){low_bits[20]}}, low_bits, 2'b00};

    always_comb begin
        case (cls)
            CL_OPER:                        imm = lit_form ? lit_ext : '0;
            CL_LOAD, CL_STORE:              imm = off_ext;
            CL_BEQZ, CL_BNEZ, CL_BR, CL_BSR: imm = disp_ext;
            default:                        imm = '0;
        endcase
    end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
    import rdec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_valid,
    input  logic [31:0]     insn,
    output logic            dec_valid,
    output logic            dec_illegal,
    output logic [4:0]      ra_idx,
    output logic [4:0]      rb_idx,
    output logic [4:0]      dst_idx,
    output logic            reg_wen,
    output logic [2:0]      alu_op,
    output logic            b_sel_imm,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [1:0]      br_kind,
    output logic            jump,
    output logic            link,
    output logic            halt,
    output logic [XLEN-1:0] imm
);
    iclass_e         cls;
    alu_op_e         opr_alu;
    logic            opr_legal;
    logic [XLEN-1:0] imm_raw;

    ctl_t            ctl_d, ctl_q;
    logic [XLEN-1:0] imm_d, imm_q;

    rdec_class u_class (
        .opcode (insn[31:26]),
        .cls    (cls)
    );

    rdec_operate u_oper (
        .logic_grp (insn[26]),
        .func      (insn[11:5]),
        .op        (opr_alu),
        .legal     (opr_legal)
    );

    rdec_imm #(.XLEN(XLEN)) u_imm (
        .cls      (cls),
        .low_bits (insn[20:0]),
        .lit_form (insn[12]),
        .imm      (imm_raw)
    );

    always_comb begin
        logic has_dst;
        ctl_d     = '0;
        imm_d     = '0;
        has_dst   = 1'b0;
        ctl_d.vld = insn_valid;
        ctl_d.ra  = insn[25:21];
        ctl_d.rb  = insn[20:16];
        if (insn_valid) begin
            case (cls)
                CL_OPER: begin
                    if (opr_legal) begin
                        ctl_d.alu  = opr_alu;
                        ctl_d.bimm = insn[12];
                        ctl_d.dst  = insn[4:0];
                        has_dst    = 1'b1;
                        imm_d      = imm_raw;
                    end else begin
                        ctl_d.illegal = 1'b1;
                    end
                end
                CL_LOAD: begin
                    ctl_d.rd   = 1'b1;
                    ctl_d.bimm = 1'b1;
                    ctl_d.dst  = insn[25:21];
                    has_dst    = 1'b1;
                    imm_d      = imm_raw;
                end
                CL_STORE: begin
                    ctl_d.wr   = 1'b1;
                    ctl_d.bimm = 1'b1;
                    imm_d      = imm_raw;
                end
                CL_BEQZ: begin
                    ctl_d.br = BRK_EQZ;
                    imm_d    = imm_raw;
                end
                CL_BNEZ: begin
                    ctl_d.br = BRK_NEZ;
                    imm_d    = imm_raw;
                end
                CL_BR, CL_BSR: begin
                    ctl_d.br   = BRK_ALWAYS;
                    ctl_d.link = 1'b1;
                    ctl_d.dst  = insn[25:21];
                    has_dst    = 1'b1;
                    imm_d      = imm_raw;
                end
                CL_JMP: begin
                    ctl_d.jump = 1'b1;
                    ctl_d.link = 1'b1;
                    ctl_d.dst  = insn[25:21];
                    has_dst    = 1'b1;
                end
                CL_HALT: ctl_d.halt = 1'b1;
                default: ctl_d.illegal = 1'b1;
            endcase
        end
        ctl_d.we = has_dst && (ctl_d.dst != ZERO_REG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            imm_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            imm_q <= imm_d;
        end
    end

    assign dec_valid   = ctl_q.vld;
    assign dec_illegal = ctl_q.illegal;
    assign ra_idx      = ctl_q.ra;
    assign rb_idx      = ctl_q.rb;
    assign dst_idx     = ctl_q.dst;
    assign reg_wen     = ctl_q.we;
    assign alu_op      = ctl_q.alu;
    assign b_sel_imm   = ctl_q.bimm;
    assign mem_rd      = ctl_q.rd;
    assign mem_wr      = ctl_q.wr;
    assign br_kind     = ctl_q.br;
    assign jump        = ctl_q.jump;
    assign link        = ctl_q.link;
    assign halt        = ctl_q.halt;
    assign imm         = imm_q;

    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !reg_wen && !mem_rd) else $error("store with write"); // R7
    AST_NO_R31_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wen |-> dst_idx != ZERO_REG) else $error("r31 written"); // R12
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dec_illegal |-> !(reg_wen || mem_rd || mem_wr || jump || link || halt) && br_kind == 2'd0)
        else $error("illegal word enabled something"); // R11
    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, jump, halt, dec_illegal, br_kind != 2'd0}))
        else $error("two classes at once"); // R8
    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !(dec_illegal || reg_wen || mem_rd || mem_wr || halt || jump))
        else $error("output while not valid"); // R13

endmodule

// File: tb/tb_insn_decoder.sv
module tb_insn_decoder;

    typedef struct packed {
        logic        vld;
        logic        ill;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [4:0]  dst;
        logic        we;
        logic [2:0]  alu;
        logic        bimm;
        logic        rd;
        logic        wr;
        logic [1:0]  br;
        logic        jump;
        logic        link;
        logic        halt;
        logic [63:0] imm;
    } obs_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic        dec_valid, dec_illegal, reg_wen, b_sel_imm, mem_rd, mem_wr, jump, link, halt;
    logic [4:0]  ra_idx, rb_idx, dst_idx;
    logic [2:0]  alu_op;
    logic [1:0]  br_kind;
    logic [63:0] imm;

    int   n_checks = 0;
    int   n_fail   = 0;
    obs_t expv;
    string exp_tag;

    always #4 clk = ~clk;

    insn_decoder dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .dec_valid(dec_valid), .dec_illegal(dec_illegal), .ra_idx(ra_idx),
        .rb_idx(rb_idx), .dst_idx(dst_idx), .reg_wen(reg_wen), .alu_op(alu_op),
        .b_sel_imm(b_sel_imm), .mem_rd(mem_rd), .mem_wr(mem_wr), .br_kind(br_kind),
        .jump(jump), .link(link), .halt(halt), .imm(imm)
    );

    function automatic obs_t observe();
        return '{dec_valid, dec_illegal, ra_idx, rb_idx, dst_idx, reg_wen, alu_op,
                 b_sel_imm, mem_rd, mem_wr, br_kind, jump, link, halt, imm};
    endfunction

    function automatic obs_t model(input logic v, input logic [31:0] w);
        obs_t   e;
        longint sx;
        logic [5:0] op;
        e = '0;
        e.vld = v;
        e.ra = w[25:21];
        e.rb = w[20:16];
        op = w[31:26];
        if (v) begin
            if (op == 6'h10 || op == 6'h11) begin
                int code;
                code = -1;
                if (op == 6'h10 && w[11:5] == 7'h20) code = 0;
                if (op == 6'h10 && w[11:5] == 7'h29) code = 1;
                if (op == 6'h11 && w[11:5] == 7'h20) code = 2;
                if (op == 6'h11 && w[11:5] == 7'h40) code = 3;
                if (op == 6'h11 && w[11:5] == 7'h24) code = 4;
                if (op == 6'h11 && w[11:5] == 7'h4D) code = 5;
                if (code < 0) e.ill = 1'b1;
                else begin
                    e.alu  = 3'(code);
                    e.bimm = w[12];
                    e.imm  = w[12] ? 64'(w[20:13]) : 64'd0;
                    e.dst  = w[4:0];
                    e.we   = (w[4:0] != 5'd31);
                end
            end else if (op == 6'h29 || op == 6'h2D) begin
                sx = longint'($signed(w[15:0]));
                e.imm  = sx;
                e.bimm = 1'b1;
                if (op == 6'h29) begin
                    e.rd = 1'b1; e.dst = w[25:21]; e.we = (w[25:21] != 5'd31);
                end else e.wr = 1'b1;
            end else if (op == 6'h39 || op == 6'h3D || op == 6'h30 || op == 6'h34) begin
                sx = longint'($signed(w[20:0]));
                e.imm = sx * 4;
                if (op == 6'h39) e.br = 2'd1;
                else if (op == 6'h3D) e.br = 2'd2;
                else begin
                    e.br = 2'd3; e.link = 1'b1; e.dst = w[25:21]; e.we = (w[25:21] != 5'd31);
                end
            end else if (op == 6'h1A) begin
                e.jump = 1'b1; e.link = 1'b1; e.dst = w[25:21]; e.we = (w[25:21] != 5'd31);
            end else if (op == 6'h00) begin
                e.halt = 1'b1;
            end else e.ill = 1'b1;
        end
        return e;
    endfunction

    function automatic string tag_of(input logic v, input logic [31:0] w);
        logic [5:0] op;
        op = w[31:26];
        if (!v) return "R2 R3 R13";
        case (op)
            6'h10, 6'h11: return "R2 R3 R4 R5 R6 R11 R12";
            6'h29, 6'h2D: return "R2 R3 R7 R12";
            6'h39, 6'h3D, 6'h30, 6'h34: return "R2 R3 R8 R12";
            6'h1A: return "R2 R3 R9 R12";
            6'h00: return "R2 R3 R10";
            default: return "R2 R3 R11";
        endcase
    endfunction

    task automatic check(input obs_t act, input obs_t ex, input string tag);
        n_checks++;
        if (act !== ex) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, ex);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] w);
        @(negedge clk);
        check(observe(), expv, exp_tag);
        insn_valid = v;
        insn = w;
        expv = model(v, w);
        exp_tag = tag_of(v, w);
    endtask

    function automatic logic [31:0] e_opr(input logic [5:0] op, input logic [4:0] a, b,
                                          input logic [6:0] fn, input logic [4:0] c);
        return {op, a, b, 3'b000, 1'b0, fn, c};
    endfunction
    function automatic logic [31:0] e_lit(input logic [5:0] op, input logic [4:0] a,
                                          input logic [7:0] lit, input logic [6:0] fn,
                                          input logic [4:0] c);
        return {op, a, lit, 1'b1, fn, c};
    endfunction
    function automatic logic [31:0] e_mem(input logic [5:0] op, input logic [4:0] a, b,
                                          input logic [15:0] off);
        return {op, a, b, off};
    endfunction
    function automatic logic [31:0] e_br(input logic [5:0] op, input logic [4:0] a,
                                         input logic [20:0] d);
        return {op, a, d};
    endfunction

    initial begin
        obs_t first, second;
        logic [5:0] ops [12];
        logic [6:0] fns [8];
        ops = '{6'h10, 6'h11, 6'h29, 6'h2D, 6'h39, 6'h3D, 6'h30, 6'h34, 6'h1A, 6'h00, 6'h10, 6'h11};
        fns = '{7'h20, 7'h29, 7'h40, 7'h24, 7'h4D, 7'h21, 7'h00, 7'h7F};
        expv = '0;
        exp_tag = "R1";
        repeat (3) @(negedge clk);
        check(observe(), '0, "R1");
        insn_valid = 1'b1;
        insn = 32'hFFFF_FFFF;
        @(negedge clk);
        check(observe(), '0, "R1");
        insn_valid = 1'b0;
        insn = '0;
        rst_n = 1'b1;
        expv = model(1'b0, 32'd0);
        exp_tag = "R2 R13";

        step(1, e_opr(6'h10, 5'd1, 5'd2, 7'h20, 5'd3));
        step(1, e_lit(6'h11, 5'd4, 8'h3f, 7'h40, 5'd5));
        step(1, e_opr(6'h10, 5'd7, 5'd8, 7'h29, 5'd9));
        step(1, e_lit(6'h11, 5'd1, 8'hff, 7'h20, 5'd31));
        step(1, e_opr(6'h11, 5'd2, 5'd3, 7'h24, 5'd4));
        step(1, e_opr(6'h11, 5'd2, 5'd3, 7'h4D, 5'd6));
        step(1, e_opr(6'h10, 5'd2, 5'd3, 7'h40, 5'd6));
        step(1, e_mem(6'h29, 5'd6, 5'd7, 16'h0abc));
        step(1, e_mem(6'h29, 5'd31, 5'd7, 16'h8000));
        step(1, e_mem(6'h2D, 5'd8, 5'd9, 16'hfff0));
        step(1, e_br(6'h39, 5'd3, 21'h1ffffb));
        step(1, e_br(6'h3D, 5'd3, 21'h000010));
        step(1, e_br(6'h34, 5'd26, 21'h1ffffa));
        step(1, e_br(6'h30, 5'd31, 21'h0fffff));
        step(0, e_mem(6'h29, 5'd6, 5'd7, 16'h0001));
        step(1, 32'h6bfa_8001);
        step(1, 32'h0000_0000);
        step(1, 32'h000a_bcde);
        step(1, {6'h3F, 26'h155_5555});
        step(1, {6'h08, 26'h0});

        // R9: kind hint in bits 15:14 must not alter any output
        step(1, {6'h1A, 5'd26, 5'd4, 2'b00, 14'h0123});
        step(1, {6'h1A, 5'd26, 5'd4, 2'b10, 14'h3ffe});
        @(negedge clk);
        first = observe();
        check(first, expv, exp_tag);
        insn = {6'h1A, 5'd26, 5'd4, 2'b01, 14'h0000};
        @(negedge clk);
        second = observe();
        n_checks++;
        if (second !== first) begin
            n_fail++;
            $display("FAIL R9: actual %h expected %h", second, first);
        end
        // R10: halt ignores its low bits apart from the raw index fields
        insn = {6'h00, 5'd0, 5'd0, 16'hFFFF};
        @(negedge clk);
        first = observe();
        insn = {6'h00, 5'd0, 5'd0, 16'h1234};
        @(negedge clk);
        second = observe();
        n_checks++;
        if (second !== first || !second.halt) begin
            n_fail++;
            $display("FAIL R10: actual %h expected %h", second, first);
        end
        expv = model(1'b1, insn);
        exp_tag = tag_of(1'b1, insn);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom_range(0, 7) != 0) w[31:26] = ops[$urandom_range(0, 11)];
            if ($urandom_range(0, 3) != 0) w[11:5] = fns[$urandom_range(0, 7)];
            step(($urandom_range(0, 9) != 0), w);
        end
        step(0, 32'd0);
        step(0, 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule